// File: doc/BRIEF.md
# Parity-Checked Duplicated Datapath Wrapper

This block carries a parity-protected word through a small combinational function without leaving any point in the path unguarded. The incoming word is checked against its parity bit, and the parity bit is then dropped. The checked data goes to two identical instances of the function, A and B. A comparator checks their results against each other. A fresh parity bit is then generated for the outgoing word, which is taken from copy A. The comparison sits between the parity check and the parity generation. A single fault anywhere between them therefore shows up either as a parity failure or as a disagreement between the copies.

Copy A alone never supplies the data while copy B supplies the parity. That split is excluded on purpose. One internal fault can flip an even number of output bits, and a single parity bit cannot see such a change. The checker logic is not duplicated. A fault inside it can only raise the error flag or have no effect.

A small error state machine latches any detected fault. It has two states:
- `ST_CLEAN`: no error has been latched.
- `ST_LATCHED`: an error has been latched.

It has two transitions:
- `FAULT_SEEN` moves `ST_CLEAN` to `ST_LATCHED` on a clock edge where the instant error is high.
- `CLEARED` moves `ST_LATCHED` to `ST_CLEAN` on an edge where `clr` is high and no error is present.

A fault-injection input can flip one chosen result bit of copy B. Verification uses it to prove that every single-bit fault is caught.

Top module: `par_dup_wrap`

## Requirements
- R1: With the default function, `out_data` equals `y` in the same cycle. `y` is defined as `y[i] = x[i] ^ x[(i-1) mod W] ^ x[(i-5) mod W]`, where `x = in_data` and `W = 16`.
- R2: `out_par` is even parity over `out_data`: the XOR of all `out_data` bits. It is valid in the same cycle as `out_data`.
- R3: `err_now` is high in the same cycle whenever the XOR of `in_data` and `in_par` is 1 (even parity violated).
- R4: While `inj_en` is 1, `err_now` is high in the same cycle for every value of `inj_sel`. `inj_sel` is the index of the copy B result bit that is inverted.
- R5: `err_flag` goes high on the first rising clock edge at which `err_now` is high. The change is seen from the cycle after that edge.
- R6: Once set, `err_flag` stays high until a rising edge where `clr` is 1 and `err_now` is 0. After that edge it reads 0. If `clr` and `err_now` are both 1, the flag stays set.
- R7: An error does not stop the outputs. During injection or a bad input parity, `out_data` and `out_par` still follow R1 and R2 from copy A.
- R8: While `rst_n` is low, `err_flag` is 0. With valid parity and no injection, it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the latched error |
| in_data | input | 16 | Incoming data word |
| in_par | input | 1 | Even parity bit for `in_data` |
| inj_en | input | 1 | Enables fault injection in copy B |
| inj_sel | input | 4 | Index of the copy B result bit to invert |
| out_data | output | 16 | Result word from copy A |
| out_par | output | 1 | Regenerated even parity for `out_data` |
| err_now | output | 1 | Instant error: input parity failure or copy mismatch |
| err_flag | output | 1 | Sticky latched error |

## Verification
The function is driven with the following input patterns, each telling apart a different class of fault:
- An all-zero word and an all-ones word separate stuck rotation taps from correct wiring.
- A walking single one shows each output bit's three-input cone individually, so a wrong tap offset appears as a wrong bit position.
- Random words with correct parity exercise mixed carries through the XOR network and confirm that no false error arises.
- Words with one parity bit wrong check the input checker.
- A sweep of injected faults over every bit of copy B shows that the comparator sees each single bit. It also shows that the output still comes from copy A.
- Clear pulses issued with and without a simultaneous error separate the two outcomes of the sticky register.

// File: rtl/par_dup_pkg.sv
package par_dup_pkg;

    typedef enum logic [0:0] {
        FN_MIX = 1'b0,
        FN_ADD = 1'b1
    } fn_kind_e;

    typedef enum logic [0:0] {
        ST_CLEAN   = 1'b0,
        ST_LATCHED = 1'b1
    } err_state_e;

endpackage

// File: rtl/par_reduce.sv
module par_reduce #(
    parameter int W = 16
) (
    input  logic [W-1:0] vec,
    output logic         odd
);
    localparam int LVLS = (W <= 1) ? 1 : $clog2(W);
    localparam int PADW = 1 << LVLS;

    logic [PADW-1:0] padded;
    logic [2*PADW-2:0] tree;

    always_comb begin
        padded = '0;
        padded[W-1:0] = vec;
    end

    genvar g;
    generate
        for (g = 0; g < PADW; g++) begin : g_leaf
            assign tree[PADW-1+g] = padded[g];
        end
        for (g = PADW-2; g >= 0; g--) begin : g_node
            assign tree[g] = tree[2*g+1] ^ tree[2*g+2];
        end
    endgenerate

    assign odd = tree[0];
endmodule

// File: rtl/dup_func_core.sv
module dup_func_core
    import par_dup_pkg::*;
#(
    parameter int       W     = 16,
    parameter fn_kind_e KIND  = FN_MIX,
    parameter int       ROT_A = 1,
    parameter int       ROT_B = 5,
    parameter int       ADD_K = 16'h3C5A,
    localparam int      SELW  = (W <= 1) ? 1 : $clog2(W)
) (
    input  logic [W-1:0]    x,
    input  logic            flip_en,
    input  logic [SELW-1:0] flip_sel,
    output logic [W-1:0]    y
);
    logic [W-1:0] core_res;
    logic [W-1:0] flip_mask;

    genvar i;
    generate
        if (KIND == FN_MIX) begin : g_mix
            for (i = 0; i < W; i++) begin : g_bit
                assign core_res[i] = x[i]
                                   ^ x[(i + W - (ROT_A % W)) % W]
                                   ^ x[(i + W - (ROT_B % W)) % W];
            end
        end else begin : g_add
            localparam logic [W-1:0] KV = W'(ADD_K);
            assign core_res = x + KV;
        end
    endgenerate

    always_comb begin
        flip_mask = '0;
        for (int b = 0; b < W; b++) begin
            if (flip_en && (flip_sel == SELW'(b))) flip_mask[b] = 1'b1;
        end
    end

    assign y = core_res ^ flip_mask;
endmodule

// File: rtl/copy_compare.sv
module copy_compare #(
    parameter int W = 16
) (
    input  logic [W-1:0] res_a,
    input  logic [W-1:0] res_b,
    output logic         differ
);
    logic [W-1:0] diff_bits;
    logic [W:0]   any_chain;

    assign diff_bits = res_a ^ res_b;
    assign any_chain[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_or
            assign any_chain[i+1] = any_chain[i] | diff_bits[i];
        end
    endgenerate

    assign differ = any_chain[W];
endmodule

// File: rtl/err_latch_fsm.sv
module err_latch_fsm
    import par_dup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fault,
    output logic latched
);
    err_state_e state_q;
    err_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN: begin
                if (fault) state_d = ST_LATCHED;
            end
            ST_LATCHED: begin
                if (clr && !fault) state_d = ST_CLEAN;
            end
            default: state_d = ST_LATCHED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_CLEAN:   latched = 1'b0;
            ST_LATCHED: latched = 1'b1;
            default:    latched = 1'b1;
        endcase
    end
endmodule

// File: rtl/par_dup_wrap.sv
module par_dup_wrap
    import par_dup_pkg::*;
#(
    parameter int       W    = 16,
    parameter fn_kind_e KIND = FN_MIX,
    localparam int      SELW = (W <= 1) ? 1 : $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [W-1:0]    in_data,
    input  logic            in_par,
    input  logic            inj_en,
    input  logic [SELW-1:0] inj_sel,
    output logic [W-1:0]    out_data,
    output logic            out_par,
    output logic            err_now,
    output logic            err_flag
);
    logic [W:0]   in_word;
    logic         in_odd;
    logic [W-1:0] res_a;
    logic [W-1:0] res_b;
    logic         copies_differ;
    logic         gen_par;

    assign in_word = {in_par, in_data};

    par_reduce #(.W(W+1)) u_in_chk (
        .vec (in_word),
        .odd (in_odd)
    );

    dup_func_core #(.W(W), .KIND(KIND)) u_copy_a (
        .x        (in_data),
        .flip_en  (1'b0),
        .flip_sel ('0),
        .y        (res_a)
    );

    dup_func_core #(.W(W), .KIND(KIND)) u_copy_b (
        .x        (in_data),
        .flip_en  (inj_en),
        .flip_sel (inj_sel),
        .y        (res_b)
    );

    copy_compare #(.W(W)) u_cmp (
        .res_a  (res_a),
        .res_b  (res_b),
        .differ (copies_differ)
    );

    par_reduce #(.W(W)) u_out_gen (
        .vec (res_a),
        .odd (gen_par)
    );

    assign err_now  = in_odd | copies_differ;
    assign out_data = res_a;
    assign out_par  = gen_par;

    err_latch_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .fault   (err_now),
        .latched (err_flag)
    );
endmodule

// File: rtl/par_dup_wrap_chk.sv
module par_dup_wrap_chk #(
    parameter int  W    = 16,
    localparam int SELW = (W <= 1) ? 1 : $clog2(W)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clr,
    input logic [W-1:0]    in_data,
    input logic            in_par,
    input logic            inj_en,
    input logic [SELW-1:0] inj_sel,
    input logic [W-1:0]    out_data,
    input logic            out_par,
    input logic            err_now,
    input logic            err_flag
);
    // R3
    bad_in_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (^{in_data, in_par}) |-> err_now);

    // R4
    inject_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inj_en |-> err_now);

    // R5
    flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_now |=> err_flag);

    // R6
    flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr) |=> err_flag);

    // R6
    flag_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && clr && !err_now) |=> !err_flag);

    // R8
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag && !err_now) |=> !err_flag);

    // R2
    out_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(^{out_data, out_par}));

    // R8
    reset_flag_chk: assert property (@(posedge clk)
        !rst_n |-> !err_flag);
endmodule

bind par_dup_wrap par_dup_wrap_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_data  (in_data),
    .in_par   (in_par),
    .inj_en   (inj_en),
    .inj_sel  (inj_sel),
    .out_data (out_data),
    .out_par  (out_par),
    .err_now  (err_now),
    .err_flag (err_flag)
);

// File: tb/par_dup_wrap_test.sv
`timescale 1ns/100ps
module par_dup_wrap_test;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic [W-1:0]  in_data = '0;
    logic          in_par = 1'b0;
    logic          inj_en = 1'b0;
    logic [3:0]    inj_sel = '0;
    logic [W-1:0]  out_data;
    logic          out_par;
    logic          err_now;
    logic          err_flag;

    int checks = 0;
    int fails = 0;
    bit model_flag = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    par_dup_wrap uut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .in_data(in_data), .in_par(in_par),
        .inj_en(inj_en), .inj_sel(inj_sel),
        .out_data(out_data), .out_par(out_par),
        .err_now(err_now), .err_flag(err_flag)
    );

    function automatic logic [W-1:0] ref_fn(input logic [W-1:0] x);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++)
            r[i] = x[i] ^ x[(i + W - 1) % W] ^ x[(i + W - 5) % W];
        return r;
    endfunction

    function automatic logic even_bit(input logic [W-1:0] x);
        int n = 0;
        for (int i = 0; i < W; i++) if (x[i]) n++;
        return logic'(n % 2);
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // drive one cycle, compare at the falling edge, advance model at rising edge
    task automatic step(input logic [W-1:0] d, input bit bad_par,
                        input bit ie, input int sel, input bit c);
        bit exp_err;
        in_data = d;
        in_par  = even_bit(d) ^ bad_par;
        inj_en  = ie;
        inj_sel = 4'(sel);
        clr     = c;
        @(negedge clk);
        exp_err = bad_par | ie;
        check("R1 out_data", out_data, ref_fn(d));
        check("R2 out_par", W'(out_par), W'(even_bit(ref_fn(d))));
        check(bad_par ? "R3 err_now" : (ie ? "R4 err_now" : "R8 err_now"),
              W'(err_now), W'(exp_err));
        check(c ? "R6 err_flag" : "R5 err_flag", W'(err_flag), W'(model_flag));
        if (ie || bad_par) check("R7 out_data under error", out_data, ref_fn(d));
        @(posedge clk);
        if (exp_err)               model_flag = 1'b1;
        else if (c)                model_flag = 1'b0;
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R8 reset state
        check("R8 reset flag", W'(err_flag), '0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        model_flag = 1'b0;

        // R1 R2 pattern sweep, no errors expected (R8)
        step('0, 0, 0, 0, 0);
        step('1, 0, 0, 0, 0);
        for (int b = 0; b < W; b++) step(W'(1) << b, 0, 0, 0, 0);
        for (int k = 0; k < 40; k++) step(W'($urandom), 0, 0, 0, 0);
        check("R8 flag stays clear", W'(err_flag), '0);

        // R3 bad parity, then R6 clear
        step(16'hA5C3, 1, 0, 0, 0);
        step(16'h1234, 0, 0, 0, 0);
        step(16'h1234, 0, 0, 0, 1);
        step(16'h0F0F, 0, 0, 0, 0);

        // R4 R7 every injected bit caught, cleared each time
        for (int s = 0; s < W; s++) begin
            step(W'($urandom), 0, 1, s, 0);
            step(W'($urandom), 0, 0, 0, 0);
            step(W'($urandom), 0, 0, 0, 1);
        end

        // R6 clear coincident with an error keeps the flag
        step(16'h00FF, 1, 0, 0, 0);
        step(16'h00FF, 0, 1, 3, 1);
        step(16'h00FF, 0, 0, 0, 0);
        step(16'h00FF, 0, 0, 0, 1);
        step(16'h00FF, 0, 0, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule